// File: doc/BRIEF.md
# Five-Level Three-Phase Space-Vector Modulator

This block turns three signed reference phase voltages into pole levels for a three-phase inverter with five output levels per leg. A triangular carrier runs over one sampling interval. At the start of each interval the block takes one sample of the three references and holds it for the whole interval. From that sample it computes one common-mode offset and adds it to all three phases. Each shifted reference is then compared every clock with four triangular carriers, stacked one above another. The count of carriers lying below the reference is that phase's level.

The offset is not taken from the raw largest and smallest references. Each phase is first reduced to its position inside the carrier band it falls in. This position tells when that phase crosses a carrier during the interval. The earliest and latest of these band positions then set the offset, which keeps the middle switching vectors centred even when the phases lie in different bands. The method needs no sector search and no table.

The band height is H = 2^(CNT_W-1), which is 512 by default. The full reference span is -2H to +2H. One interval lasts 2H clocks.

Top module: `svm5_mod`

## Requirements
- R1: The carrier count starts at 0 after reset. It climbs by one per clock up to H, then falls by one per clock back to 0, so one sampling interval lasts exactly 2H clocks. An interval begins on each clock where the count is 0.
- R2: On a clock edge where the carrier count is 0 and `ref_vld` is 1, the three references are captured. At every other edge the captured references and the offset stay unchanged. This includes a count-0 edge where `ref_vld` is 0, and any edge where the references change in mid-interval.
- R3: For each phase, the band position is the reference taken modulo H, giving a value in [0, H-1]. The offset is H/2 minus floor((largest band position + smallest band position)/2). The same offset is added to all three captured references.
- R4: The carriers are numbered k = 0..3, and carrier k has the value -2H + k·H + count. Each phase's output is an unsigned 3-bit binary number from 0 to 4. It equals the number of carriers whose value is strictly below that phase's modified reference. The output is registered, so it shows the result for the count and captured sample present before the edge.
- R5: Before comparison, the modified reference is clamped to the range [-2H, +2H]. An input of +2000 therefore gives level 4 on every clock of the interval except the one at the carrier peak, where it gives 3. An input of -2000 gives level 0 on every clock.
- R6: `smp_bnd` is high for exactly one clock. It goes high after each edge that began an interval. The levels computed from a newly captured sample first appear one edge after `smp_bnd` rises.
- R7: While `rst` is high, the following are cleared at each clock edge: the carrier count, the captured references and the offset. All three levels read 2 and `smp_bnd` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | REF_W | Phase A reference, two's complement |
| ref_b | input | REF_W | Phase B reference, two's complement |
| ref_c | input | REF_W | Phase C reference, two's complement |
| ref_vld | input | 1 | Sample strobe; allows capture at the start of an interval |
| lvl_a | output | 3 | Phase A pole level, 0 to 4 |
| lvl_b | output | 3 | Phase B pole level, 0 to 4 |
| lvl_c | output | 3 | Phase C pole level, 0 to 4 |
| smp_bnd | output | 1 | One-clock pulse marking a new sampling interval |

## Verification
A capture happens on the edge where the carrier count is 0. `smp_bnd` rises one edge later. The levels derived from that sample appear one edge after that, and they keep reflecting it for the next 2H edges.

The bench models the carrier and the held sample in integer arithmetic and predicts each output for every edge. It compares all four outputs on the falling clock, after the registers have settled. The directed checks wait for a `smp_bnd` pulse and then count levels over exactly the 2H following edges. The expected counts are worked out by hand for the offset, hold and clamp cases.

// File: rtl/svm5_pkg.sv
package svm5_pkg;
  localparam int NPH   = 3;   // phases
  localparam int NCAR  = 4;   // stacked carriers for five output levels
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_MID = 3'd2;
endpackage

// File: rtl/svm5_carrier.sv
module svm5_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  localparam int HALF_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] PEAK    = CNT_W'(1) << HALF_W;
  localparam logic [CNT_W-1:0] PEAK_M1 = PEAK - CNT_W'(1);

  logic up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == PEAK_M1) up <= 1'b0;
    end else begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) up <= 1'b1;
    end
  end

  assign tick = (cnt == '0);

  AST_CNT_PEAK: assert property (@(posedge clk) disable iff (rst)
    cnt <= PEAK); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1)))); // R1
endmodule

// File: rtl/svm5_sort3.sv
module svm5_sort3 #(
  parameter int W = 9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] lo_ab, hi_ab;

  always_comb begin
    lo_ab = (a < b) ? a : b;
    hi_ab = (a < b) ? b : a;
    lo    = (c < lo_ab) ? c : lo_ab;
    hi    = (c > hi_ab) ? c : hi_ab;
  end
endmodule

// File: rtl/svm5_offset.sv
module svm5_offset
  import svm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic signed [REF_W-1:0] refs [NPH],
  output logic signed [CNT_W:0]   off
);
  localparam int HALF_W = CNT_W - 1;
  localparam int H      = 1 << HALF_W;
  localparam int OFF_W  = CNT_W + 1;

  // position inside the band = reference modulo band height
  logic [HALF_W-1:0] pos [NPH];
  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_pos
      assign pos[p] = refs[p][HALF_W-1:0];
    end
  endgenerate

  logic [HALF_W-1:0] first_x, last_x;

  svm5_sort3 #(.W(HALF_W)) u_sort (
    .a  (pos[0]),
    .b  (pos[1]),
    .c  (pos[2]),
    .lo (first_x),
    .hi (last_x)
  );

  logic [HALF_W:0] span_sum;

  always_comb begin
    span_sum = {1'b0, first_x} + {1'b0, last_x};
    off      = $signed(OFF_W'(H / 2)) - $signed({2'b00, span_sum[HALF_W:1]});
  end
endmodule

// File: rtl/svm5_level.sv
module svm5_level
  import svm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic signed [REF_W-1:0] samp,
  input  logic signed [CNT_W:0]   off,
  input  logic [CNT_W-1:0]        cnt,
  output lvl_t                    lvl
);
  localparam int HALF_W = CNT_W - 1;
  localparam int H      = 1 << HALF_W;
  localparam int SUM_W  = REF_W + 1;
  localparam int VM_W   = CNT_W + 2;
  localparam logic signed [SUM_W-1:0] SUM_TOP = SUM_W'(2 * H);
  localparam logic signed [SUM_W-1:0] SUM_BOT = SUM_W'(-2 * H);
  localparam logic signed [VM_W-1:0]  VM_TOP  = VM_W'(2 * H);
  localparam logic signed [VM_W-1:0]  VM_BOT  = VM_W'(-2 * H);
  localparam logic [VM_W-1:0]         LIFT    = VM_W'(2 * H);

  logic signed [SUM_W-1:0] sum;
  logic signed [VM_W-1:0]  vm;
  logic [VM_W-1:0]         lifted;
  logic [NCAR-1:0]         below;

  always_comb begin
    sum = SUM_W'(samp) + SUM_W'(off);
    if (sum > SUM_TOP)      vm = VM_TOP;
    else if (sum < SUM_BOT) vm = VM_BOT;
    else                    vm = VM_W'(sum);
    lifted = $unsigned(vm) + LIFT;   // 0 .. 4H
  end

  genvar k;
  generate
    for (k = 0; k < NCAR; k++) begin : g_car
      assign below[k] = ({2'b00, cnt} + VM_W'(k * H)) < lifted;
    end
  endgenerate

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NCAR; i++) lvl = lvl + lvl_t'(below[i]);
  end
endmodule

// File: rtl/svm5_mod.sv
module svm5_mod
  import svm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic                    ref_vld,
  output logic [2:0]              lvl_a,
  output logic [2:0]              lvl_b,
  output logic [2:0]              lvl_c,
  output logic                    smp_bnd
);
  localparam int H      = 1 << (CNT_W - 1);
  localparam int OFF_HI = H / 2;
  localparam int OFF_LO = H / 2 - (H - 1);

  logic signed [REF_W-1:0] ref_in [NPH];
  assign ref_in[0] = ref_a;
  assign ref_in[1] = ref_b;
  assign ref_in[2] = ref_c;

  logic [CNT_W-1:0]        cnt;
  logic                    tick;
  logic signed [CNT_W:0]   off_nxt;
  logic signed [CNT_W:0]   off_q;
  logic signed [REF_W-1:0] samp_q  [NPH];
  lvl_t                    lvl_nxt [NPH];
  lvl_t                    lvl_q   [NPH];
  logic                    bnd_q;

  svm5_carrier #(.CNT_W(CNT_W)) u_car (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .tick (tick)
  );

  svm5_offset #(.REF_W(REF_W), .CNT_W(CNT_W)) u_off (
    .refs (ref_in),
    .off  (off_nxt)
  );

  genvar p;
  generate
    for (p = 0; p < NPH; p++) begin : g_ph
      svm5_level #(.REF_W(REF_W), .CNT_W(CNT_W)) u_lvl (
        .samp (samp_q[p]),
        .off  (off_q),
        .cnt  (cnt),
        .lvl  (lvl_nxt[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      bnd_q <= 1'b0;
      for (int i = 0; i < NPH; i++) begin
        samp_q[i] <= '0;
        lvl_q[i]  <= LVL_MID;
      end
    end else begin
      bnd_q <= tick;
      if (tick && ref_vld) begin
        off_q <= off_nxt;
        for (int i = 0; i < NPH; i++) samp_q[i] <= ref_in[i];
      end
      for (int i = 0; i < NPH; i++) lvl_q[i] <= lvl_nxt[i];
    end
  end

  assign lvl_a   = lvl_q[0];
  assign lvl_b   = lvl_q[1];
  assign lvl_c   = lvl_q[2];
  assign smp_bnd = bnd_q;

  AST_OFF_SPAN: assert property (@(posedge clk) disable iff (rst)
    (off_nxt <= OFF_HI) && (off_nxt >= OFF_LO)); // R3
  AST_SMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(tick && ref_vld) |=> ($stable(off_q) && $stable(samp_q[0]) && $stable(samp_q[1]) && $stable(samp_q[2]))); // R2
  AST_SMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && ref_vld) |=> (samp_q[0] == $past(ref_a) && samp_q[2] == $past(ref_c))); // R2
  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lvl_a <= 3'(NCAR)) && (lvl_b <= 3'(NCAR)) && (lvl_c <= 3'(NCAR))); // R4
  AST_BND_ONE: assert property (@(posedge clk) disable iff (rst)
    smp_bnd |=> !smp_bnd); // R6
  AST_RST_MID: assert property (@(posedge clk)
    rst |=> (lvl_a == LVL_MID && lvl_b == LVL_MID && lvl_c == LVL_MID && !smp_bnd)); // R7
endmodule

// File: tb/sim_svm5_mod.sv
module sim_svm5_mod;
  localparam int REF_W = 12;
  localparam int CNT_W = 10;
  localparam int H     = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
  logic vld = 1'b0;
  logic [2:0] la, lb, lc;
  logic bnd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  svm5_mod #(.REF_W(REF_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .ref_a(ra), .ref_b(rb), .ref_c(rc), .ref_vld(vld),
    .lvl_a(la), .lvl_b(lb), .lvl_c(lc), .smp_bnd(bnd)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mcnt, mvm[3], el[3], eb;
  bit mup, mvalid = 0;

  function automatic int band_pos(int v);
    return ((v % H) + H) % H;
  endfunction

  function automatic int lvl_of(int vm, int c);
    int n = 0;
    for (int k = 0; k < 4; k++) if (-2 * H + k * H + c < vm) n++;
    return n;
  endfunction

  task automatic model_latch(int a, int b, int c);
    int q[$];
    int off;
    int v[3];
    v[0] = a; v[1] = b; v[2] = c;
    q = {band_pos(a), band_pos(b), band_pos(c)};
    q.sort();
    off = H / 2 - (q[0] + q[2]) / 2;
    for (int p = 0; p < 3; p++) begin
      mvm[p] = v[p] + off;
      if (mvm[p] > 2 * H)  mvm[p] = 2 * H;
      if (mvm[p] < -2 * H) mvm[p] = -2 * H;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mcnt = 0; mup = 1;
      for (int p = 0; p < 3; p++) begin mvm[p] = 0; el[p] = 2; end
      eb = 0; mvalid = 1;
    end else begin
      for (int p = 0; p < 3; p++) el[p] = lvl_of(mvm[p], mcnt);
      eb = (mcnt == 0);
      if (mcnt == 0 && vld) model_latch(int'(ra), int'(rb), int'(rc));
      if (mup) begin mcnt++; if (mcnt == H) mup = 0; end
      else begin mcnt--; if (mcnt == 0) mup = 1; end
    end
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_up();
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (mvalid && !done) begin
      chk(int'(la) == el[0], rst ? "R7 lvl_a" : "R4 lvl_a", int'(la), el[0]);
      chk(int'(lb) == el[1], rst ? "R7 lvl_b" : "R4 lvl_b", int'(lb), el[1]);
      chk(int'(lc) == el[2], rst ? "R7 lvl_c" : "R4 lvl_c", int'(lc), el[2]);
      chk(int'(bnd) == eb,   rst ? "R7 smp_bnd" : "R6 smp_bnd", int'(bnd), eb);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wait_bnd();
    @(negedge clk);
    while (bnd !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(int ta, int tb, int tc, output int na, output int nb, output int nc);
    na = 0; nb = 0; nc = 0;
    for (int i = 0; i < 2 * H; i++) begin
      @(negedge clk);
      if (int'(la) == ta) na++;
      if (int'(lb) == tb) nb++;
      if (int'(lc) == tc) nc++;
    end
  endtask

  task automatic set_ref(int a, int b, int c);
    ra = REF_W'(a); rb = REF_W'(b); rc = REF_W'(c);
  endtask

  initial begin
    int na, nb, nc, gap;
    repeat (4) @(negedge clk);
    chk(la == 3'd2 && lb == 3'd2 && lc == 3'd2, "R7 reset level", int'(la), 2);
    chk(bnd == 1'b0, "R7 reset smp_bnd", int'(bnd), 0);
    rst = 1'b0;
    vld = 1'b1;

    // R1: interval length between boundary pulses
    wait_bnd();
    gap = 0;
    do begin @(negedge clk); gap++; end while (bnd !== 1'b1);
    chk(gap == 2 * H, "R1 interval length", gap, 2 * H);

    // R3: offset from band positions (600,-100,50 -> offset 25)
    set_ref(600, -100, 50);
    wait_bnd();
    measure(4, 2, 3, na, nb, nc);
    chk(na == 225, "R3 phase A level-4 cycles", na, 225);
    chk(nb == 873, "R3 phase B level-2 cycles", nb, 873);
    chk(nc == 149, "R3 phase C level-3 cycles", nc, 149);

    // R2: strobe low at the boundary keeps the old sample
    vld = 1'b0;
    set_ref(-900, 900, 0);
    wait_bnd();
    measure(4, 2, 3, na, nb, nc);
    chk(na == 225, "R2 hold phase A", na, 225);
    chk(nb == 873, "R2 hold phase B", nb, 873);
    chk(nc == 149, "R2 hold phase C", nc, 149);
    vld = 1'b1;

    // R5: clamp of oversized references
    set_ref(2000, -2000, 0);
    wait_bnd();
    measure(4, 0, 0, na, nb, nc);
    chk(na == 2 * H - 1, "R5 clamp high", na, 2 * H - 1);
    chk(nb == 2 * H, "R5 clamp low", nb, 2 * H);

    // further patterns checked cycle by cycle, incl. mid-interval changes (R2)
    set_ref(900, -50, -850);   wait_bnd(); repeat (300) @(negedge clk);
    set_ref(-1000, 1000, 0);   wait_bnd(); wait_bnd();
    set_ref(513, 511, -1024);  wait_bnd(); repeat (700) @(negedge clk);
    set_ref(300, -100, -200);  wait_bnd(); wait_bnd();
    set_ref(1023, -1024, 7);   wait_bnd(); wait_bnd();

    // R7: reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(la == 3'd2 && lb == 3'd2 && lc == 3'd2, "R7 reset mid-run", int'(la), 2);
    rst = 1'b0;
    wait_bnd();
    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule